// File: doc/BRIEF.md
# UART Interrupt Identification Encoder

This block gathers every interrupt condition of one UART channel, keeps event-type conditions pending until the host services them, masks them with an eight-bit enable register, and reports the single most urgent one as an identification byte. It also drives an active-low interrupt line. The FIFOs, shifters and baud logic around it give it level conditions (receive data at trigger level, transmit holding register empty, the line-status byte) and one-cycle event pulses (receive timeout, modem delta, input pin change, Xoff seen, CTS change, RTS change).

The host writes the enable register over a simple write strobe. The upper four enable bits respond only while the enhanced-function flag is set. The host's reads of the line-status, modem-status, data, I/O-state and identification registers reach the block as one-cycle strobes, and each strobe retires the sources that belong to it. A pending source whose enable is off stays latched, and it is reported as soon as its enable is set.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the enable register reads 0x00, the identification byte is 0x01 and `irq_n` is 1.
- R2: A write always loads enable bits 3:0. Bit 0 is receive data and timeout, bit 1 is transmit-holding empty, bit 2 is line status and bit 3 is modem status. The value reads back on `ier_rdata` after the write edge.
- R3: Enable bits 7:4 (bit 4 sleep, bit 5 Xoff, bit 6 RTS change, bit 7 CTS change) load only when `enh_en` is 1 during the write. Otherwise they keep their old value.
- R4: Bit 0 of the identification byte is 1 when nothing is reported and 0 otherwise. Bits 5:1 carry the ID and bits 7:6 are 0. `irq_n` is low exactly when bit 0 is 0. The byte is registered: an event pulse sampled on edge k shows on edge k+1.
- R5: Line status (byte 0x06, enable bit 2) latches when any of bits 4:1 of `lsr_stat` newly becomes 1, and it is cleared by `lsr_rd`. An error bit that stays at 1 does not latch it again.
- R6: Receive data available (byte 0x04) follows the `rx_avail` level. Receive timeout (byte 0x0C) latches on `rx_tmo_evt` and clears on `rhr_rd`. Both are gated by enable bit 0.
- R7: Transmit empty (byte 0x02, enable bit 1) latches when `tx_empty` rises, or when enable bit 1 rises while `tx_empty` is 1. An `iir_rd` while 0x02 is reported clears it, and it stays clear until the holding register fills and empties again. A 0 on `tx_empty` also clears it.
- R8: Modem status (byte 0x00, enable bit 3) latches on `msr_evt` and clears on `msr_rd`.
- R9: Input pin change (byte 0x30) latches on `pin_evt`, is always enabled, and clears on `io_rd`.
- R10: Xoff received (byte 0x10, enable bit 5) latches on `xoff_evt`. An `iir_rd` while 0x10 is reported clears it.
- R11: CTS/RTS change (byte 0x20) is reported for a latched `cts_evt` when enable bit 7 is set, or for a latched `rts_evt` when enable bit 6 is set. `msr_rd` clears both.
- R12: With several sources reported at once, the one shown is the first in this list: line status, timeout, receive data, transmit empty, modem, pin change, Xoff, CTS/RTS.
- R13: A source that latches while its enable is 0 is kept, and it is reported once the enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| enh_en | input | 1 | Enhanced-function flag; unlocks enable bits 7:4 |
| ier_rdata | output | 8 | Current enable register value |
| lsr_stat | input | 8 | Line-status byte; bits 4:1 are error flags |
| rx_avail | input | 1 | Receive data at trigger level (level) |
| rx_tmo_evt | input | 1 | Receive timeout event pulse |
| tx_empty | input | 1 | Transmit holding register empty (level) |
| msr_evt | input | 1 | Modem-status delta event pulse |
| pin_evt | input | 1 | Input pin change event pulse |
| xoff_evt | input | 1 | Xoff character received pulse |
| cts_evt | input | 1 | CTS change event pulse |
| rts_evt | input | 1 | RTS change event pulse |
| lsr_rd | input | 1 | Host read of line status |
| msr_rd | input | 1 | Host read of modem status |
| rhr_rd | input | 1 | Host read of receive data |
| io_rd | input | 1 | Host read of I/O pin state |
| iir_rd | input | 1 | Host read of the identification byte |
| iir_q | output | 8 | Identification byte |
| irq_n | output | 1 | Interrupt line, active low |

## Verification
The transmit-empty clearing rule is the hardest to reach. An identification read retires that source only when the byte the host currently sees already shows 0x02. The holding register must also stay empty, and every higher source must be idle. The stimulus therefore drains the line-status, timeout and data sources one by one, checks that 0x02 has surfaced, and only then issues the read. Next it toggles `tx_empty` low and high to show that the source returns. A last step raises the source with a rising enable bit alone, since `tx_empty` stays at 1 throughout.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int unsigned IER_W      = 8;
  localparam int unsigned IER_BASE_W = 4;
  localparam int unsigned ID_W       = 5;
  localparam int unsigned STAT_W     = 8;
  localparam int unsigned NSRC       = 8;
  localparam int unsigned NSTK       = 8;

  localparam logic [STAT_W-1:0] LSR_ERR_MASK = 8'h1E;

  // enable register bit positions
  localparam int unsigned IE_RXD   = 0;
  localparam int unsigned IE_THR   = 1;
  localparam int unsigned IE_LSR   = 2;
  localparam int unsigned IE_MSR   = 3;
  localparam int unsigned IE_SLEEP = 4;
  localparam int unsigned IE_XOFF  = 5;
  localparam int unsigned IE_RTS   = 6;
  localparam int unsigned IE_CTS   = 7;

  // reported sources, index = priority (0 highest)
  localparam int unsigned S_LSR  = 0;
  localparam int unsigned S_TMO  = 1;
  localparam int unsigned S_RXD  = 2;
  localparam int unsigned S_THR  = 3;
  localparam int unsigned S_MSR  = 4;
  localparam int unsigned S_PIN  = 5;
  localparam int unsigned S_XOFF = 6;
  localparam int unsigned S_FLOW = 7;

  // latched (sticky) conditions
  localparam int unsigned K_LSR  = 0;
  localparam int unsigned K_TMO  = 1;
  localparam int unsigned K_THR  = 2;
  localparam int unsigned K_MSR  = 3;
  localparam int unsigned K_PIN  = 4;
  localparam int unsigned K_XOFF = 5;
  localparam int unsigned K_CTS  = 6;
  localparam int unsigned K_RTS  = 7;

  // ID field values (identification byte bits 5:1)
  localparam logic [ID_W-1:0] ID_LSR  = 5'h03;
  localparam logic [ID_W-1:0] ID_TMO  = 5'h06;
  localparam logic [ID_W-1:0] ID_RXD  = 5'h02;
  localparam logic [ID_W-1:0] ID_THR  = 5'h01;
  localparam logic [ID_W-1:0] ID_MSR  = 5'h00;
  localparam logic [ID_W-1:0] ID_PIN  = 5'h18;
  localparam logic [ID_W-1:0] ID_XOFF = 5'h08;
  localparam logic [ID_W-1:0] ID_FLOW = 5'h10;

  function automatic logic [ID_W-1:0] src_id(input int idx);
    logic [ID_W-1:0] r;
    case (idx)
      0:       r = ID_LSR;
      1:       r = ID_TMO;
      2:       r = ID_RXD;
      3:       r = ID_THR;
      4:       r = ID_MSR;
      5:       r = ID_PIN;
      6:       r = ID_XOFF;
      7:       r = ID_FLOW;
      default: r = ID_MSR;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
  import uart_irq_pkg::*;
#(
  parameter int unsigned W      = IER_W,
  parameter int unsigned BASE_W = IER_BASE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         enh_en,
  output logic [W-1:0] ier_q
);

  localparam int unsigned UPPER_W = W - BASE_W;

  logic [W-1:0] ier_d;

  always_comb begin
    ier_d = ier_q;
    if (wr_en) begin
      ier_d[BASE_W-1:0] = wdata[BASE_W-1:0];
      if (enh_en) begin
        ier_d[W-1:BASE_W] = wdata[W-1:BASE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q <= '0;
    end else if (wr_en) begin
      ier_q <= ier_d;
    end
  end

  p_lower_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ier_q[BASE_W-1:0] == $past(wdata[BASE_W-1:0]));

  p_upper_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !enh_en) |=> ier_q[W-1:BASE_W] == $past(ier_q[W-1:BASE_W]));

  p_upper_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && enh_en) |=> ier_q[W-1:BASE_W] == $past(wdata[W-1:BASE_W]));

  logic [UPPER_W-1:0] width_unused;
  assign width_unused = '0;

endmodule

// File: rtl/irq_source_bank.sv
module irq_source_bank
  import uart_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IER_W-1:0]  ier,
  input  logic [STAT_W-1:0] lsr_stat,
  input  logic              rx_avail,
  input  logic              rx_tmo_evt,
  input  logic              tx_empty,
  input  logic              msr_evt,
  input  logic              pin_evt,
  input  logic              xoff_evt,
  input  logic              cts_evt,
  input  logic              rts_evt,
  input  logic              lsr_rd,
  input  logic              msr_rd,
  input  logic              rhr_rd,
  input  logic              io_rd,
  input  logic              iir_rd,
  input  logic [ID_W-1:0]   shown_id,
  input  logic              shown_none,
  output logic [NSRC-1:0]   req
);

  logic [STAT_W-1:0] lsr_err;
  logic [STAT_W-1:0] lsr_prev_q;
  logic              txe_prev_q;
  logic              thr_en_prev_q;
  logic [NSTK-1:0]   stk_q, stk_d, stk_set, stk_clr;
  logic              lsr_new, thr_rise, thr_shown, xoff_shown;
  logic              sleep_unused;

  assign lsr_err      = lsr_stat & LSR_ERR_MASK;
  assign sleep_unused = ier[IE_SLEEP];

  always_comb begin
    lsr_new    = |(lsr_err & ~lsr_prev_q);
    thr_rise   = tx_empty & (~txe_prev_q | (ier[IE_THR] & ~thr_en_prev_q));
    thr_shown  = iir_rd & ~shown_none & (shown_id == ID_THR);
    xoff_shown = iir_rd & ~shown_none & (shown_id == ID_XOFF);

    stk_set         = '0;
    stk_set[K_LSR]  = lsr_new;
    stk_set[K_TMO]  = rx_tmo_evt;
    stk_set[K_THR]  = thr_rise;
    stk_set[K_MSR]  = msr_evt;
    stk_set[K_PIN]  = pin_evt;
    stk_set[K_XOFF] = xoff_evt;
    stk_set[K_CTS]  = cts_evt;
    stk_set[K_RTS]  = rts_evt;

    stk_clr         = '0;
    stk_clr[K_LSR]  = lsr_rd;
    stk_clr[K_TMO]  = rhr_rd;
    stk_clr[K_THR]  = thr_shown | ~tx_empty;
    stk_clr[K_MSR]  = msr_rd;
    stk_clr[K_PIN]  = io_rd;
    stk_clr[K_XOFF] = xoff_shown;
    stk_clr[K_CTS]  = msr_rd;
    stk_clr[K_RTS]  = msr_rd;
  end

  // every latched condition: a new event wins over a clearing read
  for (genvar k = 0; k < NSTK; k++) begin : g_stk
    assign stk_d[k] = stk_set[k] | (stk_q[k] & ~stk_clr[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stk_q         <= '0;
      lsr_prev_q    <= '0;
      txe_prev_q    <= 1'b0;
      thr_en_prev_q <= 1'b0;
    end else begin
      stk_q         <= stk_d;
      lsr_prev_q    <= lsr_err;
      txe_prev_q    <= tx_empty;
      thr_en_prev_q <= ier[IE_THR];
    end
  end

  always_comb begin
    req         = '0;
    req[S_LSR]  = stk_q[K_LSR] & ier[IE_LSR];
    req[S_TMO]  = stk_q[K_TMO] & ier[IE_RXD];
    req[S_RXD]  = rx_avail & ier[IE_RXD];
    req[S_THR]  = stk_q[K_THR] & ier[IE_THR];
    req[S_MSR]  = stk_q[K_MSR] & ier[IE_MSR];
    req[S_PIN]  = stk_q[K_PIN];
    req[S_XOFF] = stk_q[K_XOFF] & ier[IE_XOFF];
    req[S_FLOW] = (stk_q[K_CTS] & ier[IE_CTS]) | (stk_q[K_RTS] & ier[IE_RTS]);
  end

  p_lsr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !lsr_new) |=> !stk_q[K_LSR]);

  p_thr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_shown && !thr_rise) |=> !stk_q[K_THR]);

  p_thr_needs_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_empty |=> !stk_q[K_THR]);

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_irq_pkg::*;
#(
  parameter int unsigned N = NSRC
) (
  input  logic [N-1:0]    req,
  output logic [ID_W-1:0] id,
  output logic            none
);

  // scan from lowest to highest priority so the highest one wins
  always_comb begin
    id   = ID_MSR;
    none = 1'b1;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (req[i]) begin
        id   = src_id(i);
        none = 1'b0;
      end
    end
  end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ier_wr,
  input  logic [IER_W-1:0]  ier_wdata,
  input  logic              enh_en,
  output logic [IER_W-1:0]  ier_rdata,
  input  logic [STAT_W-1:0] lsr_stat,
  input  logic              rx_avail,
  input  logic              rx_tmo_evt,
  input  logic              tx_empty,
  input  logic              msr_evt,
  input  logic              pin_evt,
  input  logic              xoff_evt,
  input  logic              cts_evt,
  input  logic              rts_evt,
  input  logic              lsr_rd,
  input  logic              msr_rd,
  input  logic              rhr_rd,
  input  logic              io_rd,
  input  logic              iir_rd,
  output logic [7:0]        iir_q,
  output logic              irq_n
);

  localparam int unsigned PAD_W = 8 - ID_W - 1;

  logic [NSRC-1:0] req;
  logic [ID_W-1:0] enc_id;
  logic            enc_none;
  logic [7:0]      iir_d;
  logic            irq_n_d;

  irq_enable_reg #(.W(IER_W), .BASE_W(IER_BASE_W)) u_ier (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ier_wr),
    .wdata  (ier_wdata),
    .enh_en (enh_en),
    .ier_q  (ier_rdata)
  );

  irq_source_bank u_src (
    .clk        (clk),
    .rst_n      (rst_n),
    .ier        (ier_rdata),
    .lsr_stat   (lsr_stat),
    .rx_avail   (rx_avail),
    .rx_tmo_evt (rx_tmo_evt),
    .tx_empty   (tx_empty),
    .msr_evt    (msr_evt),
    .pin_evt    (pin_evt),
    .xoff_evt   (xoff_evt),
    .cts_evt    (cts_evt),
    .rts_evt    (rts_evt),
    .lsr_rd     (lsr_rd),
    .msr_rd     (msr_rd),
    .rhr_rd     (rhr_rd),
    .io_rd      (io_rd),
    .iir_rd     (iir_rd),
    .shown_id   (iir_q[ID_W:1]),
    .shown_none (iir_q[0]),
    .req        (req)
  );

  irq_prio_enc #(.N(NSRC)) u_enc (
    .req  (req),
    .id   (enc_id),
    .none (enc_none)
  );

  always_comb begin
    iir_d   = {{PAD_W{1'b0}}, enc_id, enc_none};
    irq_n_d = ~(|req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iir_q <= 8'h01;
      irq_n <= 1'b1;
    end else begin
      iir_q <= iir_d;
      irq_n <= irq_n_d;
    end
  end

  p_line_agrees_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n == iir_q[0]);

  p_none_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    iir_q[0] |-> iir_q[7:1] == 7'h00);

  p_lsr_first_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req[S_LSR] |=> iir_q == {{PAD_W{1'b0}}, ID_LSR, 1'b0});

  p_pin_shown_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req == (NSRC'(1) << S_PIN)) |=> iir_q == 8'h30);

endmodule

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ier_wr, enh_en;
  logic [7:0] ier_wdata, ier_rdata, lsr_stat, iir_q;
  logic       rx_avail, rx_tmo_evt, tx_empty, msr_evt, pin_evt, xoff_evt;
  logic       cts_evt, rts_evt, lsr_rd, msr_rd, rhr_rd, io_rd, iir_rd, irq_n;

  typedef struct {
    bit         is_ier;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  event  chk_ev;
  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_ident uut (
    .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
    .enh_en(enh_en), .ier_rdata(ier_rdata), .lsr_stat(lsr_stat),
    .rx_avail(rx_avail), .rx_tmo_evt(rx_tmo_evt), .tx_empty(tx_empty),
    .msr_evt(msr_evt), .pin_evt(pin_evt), .xoff_evt(xoff_evt),
    .cts_evt(cts_evt), .rts_evt(rts_evt), .lsr_rd(lsr_rd), .msr_rd(msr_rd),
    .rhr_rd(rhr_rd), .io_rd(io_rd), .iir_rd(iir_rd), .iir_q(iir_q),
    .irq_n(irq_n)
  );

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_tests++;
        if (it.is_ier) begin
          if (ier_rdata !== it.exp) begin
            n_fail++;
            $display("FAIL %s: enable actual=%02h expected=%02h", it.tag, ier_rdata, it.exp);
          end
        end else if (iir_q !== it.exp || irq_n !== it.exp[0]) begin
          n_fail++;
          $display("FAIL %s: ident actual=%02h/irq_n=%b expected=%02h/irq_n=%b",
                   it.tag, iir_q, irq_n, it.exp, it.exp[0]);
        end
      end
    end
  end

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic exp_iir(input logic [7:0] e, input string tag);
    item_t it;
    it.is_ier = 1'b0; it.exp = e; it.tag = tag;
    q.push_back(it);
    -> chk_ev;
    #1;
  endtask

  task automatic exp_ier(input logic [7:0] e, input string tag);
    item_t it;
    it.is_ier = 1'b1; it.exp = e; it.tag = tag;
    q.push_back(it);
    -> chk_ev;
    #1;
  endtask

  task automatic wr_ier(input logic [7:0] v, input logic enh);
    enh_en = enh; ier_wdata = v; ier_wr = 1'b1;
    @(negedge clk);
    ier_wr = 1'b0; enh_en = 1'b0;
    settle();
  endtask

  // 0 msr_evt 1 pin_evt 2 xoff_evt 3 cts_evt 4 rts_evt 5 rx_tmo_evt
  // 6 lsr_rd 7 msr_rd 8 rhr_rd 9 io_rd 10 iir_rd
  task automatic pulse(input int which);
    case (which)
      0: msr_evt = 1'b1;  1: pin_evt = 1'b1;  2: xoff_evt = 1'b1;
      3: cts_evt = 1'b1;  4: rts_evt = 1'b1;  5: rx_tmo_evt = 1'b1;
      6: lsr_rd = 1'b1;   7: msr_rd = 1'b1;   8: rhr_rd = 1'b1;
      9: io_rd = 1'b1;    default: iir_rd = 1'b1;
    endcase
    @(negedge clk);
    {msr_evt, pin_evt, xoff_evt, cts_evt, rts_evt, rx_tmo_evt} = '0;
    {lsr_rd, msr_rd, rhr_rd, io_rd, iir_rd} = '0;
    settle();
  endtask

  initial begin
    rst_n = 1'b0; ier_wr = 1'b0; enh_en = 1'b0; ier_wdata = '0; lsr_stat = '0;
    rx_avail = 1'b0; tx_empty = 1'b0;
    {msr_evt, pin_evt, xoff_evt, cts_evt, rts_evt, rx_tmo_evt} = '0;
    {lsr_rd, msr_rd, rhr_rd, io_rd, iir_rd} = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    settle();
    exp_ier(8'h00, "R1 reset enable");
    exp_iir(8'h01, "R1 reset ident");

    wr_ier(8'hFF, 1'b0); exp_ier(8'h0F, "R3 upper locked without flag");
    exp_iir(8'h01, "R2 enables alone raise nothing");
    wr_ier(8'hFF, 1'b1); exp_ier(8'hFF, "R2 R3 full write with flag");
    wr_ier(8'h00, 1'b0); exp_ier(8'hF0, "R3 upper kept, R2 lower cleared");
    wr_ier(8'hEF, 1'b1); exp_ier(8'hEF, "R3 upper loaded");

    pulse(0); exp_iir(8'h00, "R8 R4 modem shown, line low");
    pulse(1); exp_iir(8'h00, "R12 modem over pin change");
    pulse(7); exp_iir(8'h30, "R9 pin change after modem read");
    pulse(2); exp_iir(8'h30, "R12 pin change over Xoff");
    pulse(9); exp_iir(8'h10, "R10 Xoff after io read");
    pulse(3); exp_iir(8'h10, "R12 Xoff over CTS change");
    pulse(10); exp_iir(8'h20, "R10 Xoff cleared by ident read, R11 shown");
    pulse(7); exp_iir(8'h01, "R11 cleared by modem read");

    tx_empty = 1'b1; settle(); exp_iir(8'h02, "R7 holding empty rises");
    rx_avail = 1'b1; settle(); exp_iir(8'h04, "R6 R12 data over tx empty");
    pulse(5); exp_iir(8'h0C, "R6 R12 timeout over data");
    lsr_stat = 8'h08; settle(); exp_iir(8'h06, "R5 R12 line status highest");
    pulse(6); exp_iir(8'h0C, "R5 cleared, held error does not relatch");
    lsr_stat = 8'h00; settle();
    pulse(8); exp_iir(8'h04, "R6 timeout cleared by data read");
    rx_avail = 1'b0; settle(); exp_iir(8'h02, "R6 data level gone");
    pulse(10); exp_iir(8'h01, "R7 cleared by ident read");
    settle(); exp_iir(8'h01, "R7 stays clear while still empty");
    tx_empty = 1'b0; settle();
    tx_empty = 1'b1; settle(); exp_iir(8'h02, "R7 re-raised after refill");
    pulse(10); exp_iir(8'h01, "R7 cleared again");

    wr_ier(8'h00, 1'b1); exp_iir(8'h01, "R13 all disabled");
    pulse(0); exp_iir(8'h01, "R13 masked modem event hidden");
    wr_ier(8'h08, 1'b1); exp_iir(8'h00, "R13 kept event shown on enable");
    pulse(7); exp_iir(8'h01, "R8 modem cleared");

    wr_ier(8'h40, 1'b1);
    pulse(3); exp_iir(8'h01, "R11 CTS gated by bit 7");
    pulse(4); exp_iir(8'h20, "R11 RTS via bit 6");
    pulse(7); exp_iir(8'h01, "R11 both cleared by modem read");

    wr_ier(8'h42, 1'b1); exp_iir(8'h02, "R7 enable rise while empty");
    pulse(10); exp_iir(8'h01, "R7 cleared after enable rise");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule